// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller watches a bank of interrupt request lines and decides which one the processor core should take next. Each source has its own enable bit and an 8-bit urgency value, where a smaller number is more urgent. A master enable gates every source. The controller latches a pending bit on each rising request edge. It offers the most urgent eligible source to the core as a request plus a source number.

When the core takes a request, it acknowledges it. The controller then pushes that source's level onto an internal nesting stack, and the top of that stack becomes the running level. Only a strictly more urgent request can interrupt the running handler. An exception-return strobe pops the stack and restores the level that was running before. Sources that share a level take turns through a rotating pointer kept for each level. A threshold register lets software hold back less urgent requests during a critical section while the master enable stays on.

Software configures the block through a small write-only port. Fetching the handler address and saving processor context are done elsewhere.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, no request is offered, the nesting depth is 0, no handler is active, all pending bits are 0, the overflow flag is 0, and the master enable and all source enables are off.
- R2: A source's pending bit is set on the clock edge that sees its request line go from 0 to 1. A line held high does not set it again. The bit is cleared when that source is acknowledged, or by writing 1 to its bit at address 3. If a rising edge and a clear land on the same edge, the set wins.
- R3: A pending source takes part in arbitration only when the master enable (address 0, bit 0) is 1 and its own enable bit (address 2, bit i) is 1. A disabled source keeps its pending bit.
- R4: Among eligible sources the one with the numerically lowest level is offered. Levels are written at address 16+i, 8 bits, 0 to 255.
- R5: While a handler is active, a source is eligible only if its level is strictly lower than the active level. An equal level does not preempt.
- R6: Among eligible sources at the winning level, the first one found at or after that level's rotating pointer (wrapping past the last source) is offered. After each acknowledge, that level's pointer moves to the source just after the granted one. Every pointer starts at source 0.
- R7: An acknowledge while a request is offered pushes the granted level. The nesting depth rises by one and the active level becomes the granted level. An exception return pops one entry and restores the previous active level. An exception return at depth 0 has no effect.
- R8: A threshold of 0 (address 1) masks nothing. A nonzero threshold blocks every source whose level is greater than or equal to it.
- R9: At the full depth of 8, no request is offered. The overflow flag becomes 1 on the next edge if any source would otherwise be eligible, and it stays at 1 until a write to address 0 with bit 1 set.
- R10: An acknowledge with no request offered is ignored. If an acknowledge and an exception return arrive together, the acknowledge takes effect and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address: 0 control, 1 threshold, 2 enables, 3 pending clear, 16+i level of source i |
| wr_data | input | 8 | Register write data |
| req_in | input | 8 | Interrupt request lines, one per source |
| irq_ack | input | 1 | Core takes the offered request |
| irq_ret | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | A request is offered to the core |
| irq_id | output | 3 | Number of the offered source |
| act_valid | output | 1 | At least one handler is active |
| act_lvl | output | 8 | Level of the innermost active handler (0 when none) |
| nest_depth | output | 4 | Number of nested active handlers |
| pend_o | output | 8 | Pending bits |
| ovf | output | 1 | Sticky flag: a preemption was held back by a full stack |

## Verification
The hardest state to reach is a stack that is completely full while a new, more urgent source is waiting. Reaching it takes eight handlers, each more urgent than the one before, then reprogramming a source that has already been served to a more urgent level and toggling its line to raise a fresh edge. The bench builds that chain one source at a time. It checks that the waiting request stays hidden and raises the overflow flag. After one return, the same request must preempt the handler that is then on top. Round-robin order is covered by sweeping all 255 request patterns at one shared level while the bench tracks the expected pointer.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NSRC  = 8,
  parameter int PW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int PBASE = 16,
  localparam int DW   = (NSRC > PW) ? NSRC : PW,
  localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DEPW = $clog2(DEPTH + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] req_in,
  input  logic            irq_ack,
  input  logic            irq_ret,
  output logic            irq_req,
  output logic [IDW-1:0]  irq_id,
  output logic            act_valid,
  output logic [PW-1:0]   act_lvl,
  output logic [DEPW-1:0] nest_depth,
  output logic [NSRC-1:0] pend_o,
  output logic            ovf
);
  localparam int NLVL = 1 << PW;

  logic            gen_en;
  logic [PW-1:0]   bmask;
  logic [NSRC-1:0] en, pend, req_q, elig;
  logic [PW-1:0]   prio [NSRC];
  logic [IDW-1:0]  rr [NLVL];
  logic [PW-1:0]   stk [DEPTH];
  logic [DEPW-1:0] depth;
  logic [PW-1:0]   top, best;
  logic [IDW-1:0]  sel;
  logic            found, full, grant, ovf_q;

  wire wr_ctrl = wr_en && wr_addr == AW'(0);
  wire wr_mask = wr_en && wr_addr == AW'(1);
  wire wr_ena  = wr_en && wr_addr == AW'(2);
  wire wr_pclr = wr_en && wr_addr == AW'(3);
  wire [NSRC-1:0] rise = req_in & ~req_q;

  always_comb begin
    top = '0;
    for (int j = 0; j < DEPTH; j++)
      if (DEPW'(j + 1) == depth) top = stk[j];
  end

  assign act_valid  = depth != '0;
  assign act_lvl    = top;
  assign full       = depth == DEPW'(DEPTH);
  assign nest_depth = depth;
  assign pend_o     = pend;
  assign ovf        = ovf_q;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      elig[i] = pend[i] && en[i] && gen_en
             && (bmask == '0 || prio[i] < bmask)
             && (!act_valid || prio[i] < top);
  end

  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < NSRC; i++)
      if (elig[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        best  = prio[i];
      end
  end

  always_comb begin
    int  idx;
    logic hit;
    hit = 1'b0;
    sel = '0;
    for (int k = 0; k < NSRC; k++) begin
      idx = (int'(rr[best]) + k) % NSRC;
      if (!hit && elig[idx] && prio[idx] == best) begin
        hit = 1'b1;
        sel = IDW'(idx);
      end
    end
  end

  assign irq_req = found && !full;
  assign irq_id  = sel;
  assign grant   = irq_ack && irq_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      bmask  <= '0;
      en     <= '0;
      pend   <= '0;
      req_q  <= '0;
      depth  <= '0;
      ovf_q  <= 1'b0;
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
      for (int j = 0; j < DEPTH; j++) stk[j] <= '0;
      for (int l = 0; l < NLVL; l++) rr[l] <= '0;
    end else begin
      req_q <= req_in;
      if (wr_ctrl) gen_en <= wr_data[0];
      if (wr_mask) bmask  <= wr_data[PW-1:0];
      if (wr_ena)  en     <= wr_data[NSRC-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (wr_en && wr_addr == AW'(PBASE + i)) prio[i] <= wr_data[PW-1:0];
        if (rise[i])
          pend[i] <= 1'b1;
        else if ((grant && sel == IDW'(i)) || (wr_pclr && wr_data[i]))
          pend[i] <= 1'b0;
      end
      if (grant) begin
        for (int j = 0; j < DEPTH; j++)
          if (DEPW'(j) == depth) stk[j] <= best;
        depth    <= depth + DEPW'(1);
        rr[best] <= (sel == IDW'(NSRC - 1)) ? '0 : sel + IDW'(1);
      end else if (irq_ret && act_valid) begin
        depth <= depth - DEPW'(1);
      end
      if (found && full)
        ovf_q <= 1'b1;
      else if (wr_ctrl && wr_data[1])
        ovf_q <= 1'b0;
    end
  end

  // R3
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gen_en && en[irq_id] && pend[irq_id]);

  // R5
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && act_valid |-> prio[irq_id] < act_lvl);

  // R8
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && bmask != '0 |-> prio[irq_id] < bmask);

  // R7
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && irq_req |=> nest_depth == $past(nest_depth) + DEPW'(1)
                          && act_lvl == $past(prio[irq_id]));

  // R7
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ret && !irq_ack && nest_depth != '0 |=> nest_depth == $past(nest_depth) - DEPW'(1));

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= DEPW'(DEPTH));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(wr_en && wr_addr == AW'(0) && wr_data[1]) |=> ovf);
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, req_in = '0;
  logic irq_ack = 1'b0, irq_ret = 1'b0;
  logic irq_req, act_valid, ovf;
  logic [2:0] irq_id;
  logic [7:0] act_lvl, pend_o;
  logic [3:0] nest_depth;
  int vecs = 0, fails = 0;
  bit done = 1'b0;

  nest_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req_in(req_in), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_id(irq_id), .act_valid(act_valid), .act_lvl(act_lvl),
    .nest_depth(nest_depth), .pend_o(pend_o), .ovf(ovf));

  always #2 clk = ~clk;

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d); tick(); wr_en = 1'b0;
  endtask
  task automatic ack(); irq_ack = 1'b1; tick(); irq_ack = 1'b0; endtask
  task automatic ret(); irq_ret = 1'b1; tick(); irq_ret = 1'b0; endtask
  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask
  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [7:0] pb [8];
    logic [7:0] rem;
    int ptr, e, n, cexp;
    tick(); tick(); rst_n = 1'b1; tick();

    // R1 reset state; enables off so a raised line is held pending only
    chk("R1 req", irq_req, 0); chk("R1 depth", nest_depth, 0);
    chk("R1 act", act_valid, 0); chk("R1 pend", pend_o, 0); chk("R1 ovf", ovf, 0);
    req_in = 8'h01; tick();
    chk("R1 gated", irq_req, 0); chk("R1 pend set", pend_o, 1);
    req_in = 0; wr(3, 8'hFF);

    // R6 round robin over every request pattern at one shared level
    wr(0, 1); wr(2, 8'hFF);
    for (int i = 0; i < 8; i++) wr(16 + i, 100);
    ptr = 0;
    for (int p = 1; p < 256; p++) begin
      req_in = 8'(p); tick(); rem = 8'(p);
      while (rem != 0) begin
        e = -1;
        for (int k = 0; k < 8; k++) if (e < 0 && rem[(ptr + k) % 8]) e = (ptr + k) % 8;
        chk("R6 req", irq_req, 1); chk("R6 id", irq_id, e);
        ack(); chk("R5 equal no preempt", irq_req, 0);
        rem[e] = 1'b0; ptr = (e + 1) % 8; ret();
      end
      req_in = 0; tick();
    end

    // R4 lowest value wins; R5 and R7 across service order
    for (int t = 0; t < 24; t++) begin
      for (int i = 0; i < 8; i++) begin pb[i] = 8'((i * 37 + t * 11) % 256); wr(16 + i, pb[i]); end
      req_in = 8'hFF; tick(); rem = 8'hFF;
      for (int s = 0; s < 8; s++) begin
        e = -1;
        for (int i = 0; i < 8; i++) if (rem[i] && (e < 0 || pb[i] < pb[e])) e = i;
        chk("R4 req", irq_req, 1); chk("R4 id", irq_id, e);
        ack(); chk("R5 no preempt", irq_req, 0); chk("R7 level", act_lvl, pb[e]);
        rem[e] = 1'b0; ret();
      end
      chk("R7 idle", act_valid, 0);
      req_in = 0; tick();
    end

    // R8 threshold sweep with levels 10+30*i
    for (int i = 0; i < 8; i++) wr(16 + i, 10 + 30 * i);
    for (int m = 0; m < 256; m += 3) begin
      wr(1, m); req_in = 8'hFF; tick(); n = 0;
      while (irq_req && n < 9) begin ack(); ret(); n++; end
      cexp = 0;
      for (int i = 0; i < 8; i++) if (m == 0 || 10 + 30 * i < m) cexp++;
      chk("R8 served", n, cexp);
      chk("R8 left", pend_o, (8'hFF << cexp) & 8'hFF);
      wr(3, 8'hFF); chk("R2 sw clear", pend_o, 0);
      req_in = 0; tick();
    end
    wr(1, 0);

    // R3 every enable pattern
    wr(2, 0); req_in = 8'hFF; tick();
    chk("R3 none enabled", irq_req, 0); chk("R3 pend kept", pend_o, 8'hFF);
    for (int en = 0; en < 256; en++) begin
      wr(2, en);
      chk("R3 req", irq_req, en != 0 ? 1 : 0);
      if (en != 0) begin
        e = -1;
        for (int i = 7; i >= 0; i--) if (en[i]) e = i;
        chk("R3 id", irq_id, e);
      end
    end
    wr(0, 0); chk("R3 global off", irq_req, 0); chk("R3 pend global", pend_o, 8'hFF);
    wr(0, 1); wr(3, 8'hFF); req_in = 0; tick();

    // R7 and R9 eight nested handlers then a blocked preemption
    for (int i = 0; i < 8; i++) wr(16 + i, 200 - 20 * i);
    for (int i = 0; i < 8; i++) begin
      req_in[i] = 1'b1; tick();
      chk("R7 nest id", irq_id, i); ack();
      chk("R7 nest lvl", act_lvl, 200 - 20 * i); chk("R7 nest depth", nest_depth, i + 1);
    end
    wr(16, 10); req_in[0] = 1'b0; tick(); req_in[0] = 1'b1; tick();
    chk("R9 full blocks", irq_req, 0); tick();
    chk("R9 ovf set", ovf, 1);
    ret();
    chk("R9 depth", nest_depth, 7); chk("R7 restored", act_lvl, 80);
    chk("R9 preempt after pop", irq_req, 1); chk("R9 id", irq_id, 0);
    ack(); chk("R7 top", act_lvl, 10); chk("R7 depth8", nest_depth, 8);
    for (int j = 0; j < 7; j++) begin ret(); chk("R7 unwind", act_lvl, 80 + 20 * j); end
    ret(); chk("R7 empty", act_valid, 0);
    ret(); chk("R7 extra ret", nest_depth, 0);
    chk("R9 ovf sticky", ovf, 1);
    wr(0, 3); chk("R9 ovf clear", ovf, 0);
    req_in = 0; tick();

    // R5 equal level does not preempt
    wr(16, 50); wr(17, 50);
    req_in = 8'h01; tick(); ack();
    req_in = 8'h03; tick(); chk("R5 equal", irq_req, 0);
    ret(); chk("R5 after ret", irq_req, 1); chk("R5 id", irq_id, 1);
    ack(); ret(); req_in = 0; tick();

    // R2 held line does not retrigger; set beats clear
    wr(19, 40); req_in = 8'h08; tick(); chk("R2 latch", pend_o, 8'h08);
    ack(); chk("R2 ack clears", pend_o, 0); ret(); tick(); tick();
    chk("R2 held", pend_o, 0); chk("R2 held req", irq_req, 0);
    req_in = 0; tick(); req_in = 8'h08; wr(3, 8'h08);
    chk("R2 set wins", pend_o, 8'h08);
    wr(3, 8'h08); chk("R2 clear", pend_o, 0); req_in = 0; tick();

    // R10 stray acknowledge; acknowledge with return
    ack(); chk("R10 stray ack", nest_depth, 0);
    req_in = 8'h04; tick();
    irq_ack = 1'b1; irq_ret = 1'b1; tick(); irq_ack = 1'b0; irq_ret = 1'b0;
    chk("R10 ack wins", nest_depth, 1);
    ret(); chk("R10 pop", nest_depth, 0); req_in = 0; tick();

    summary();
  end
endmodule